// File: doc/BRIEF.md
# Double-Buffered Bulk OUT Endpoint Buffer Manager

This block keeps the bookkeeping for a pair of packet buffers that serve one bulk OUT endpoint. Each packet that arrives from the host lands in a buffer that is free. For each buffer the block records whether it holds data and how many bytes it holds. Every stored packet raises the endpoint interrupt for one cycle. When both buffers hold data, the block asks the bus-facing logic to NAK further packets.

Software, or a DMA engine, works on one buffer at a time. That buffer is the active buffer. The active buffer changes only when the software side issues a clear command, or a validate command that acts in the same way. Either command frees the active buffer and hands the other buffer to the reader. The packet RAM and the serial engine sit outside this block. This block only decides where a packet goes and what the reader sees.

Top module: `bulk_pingpong_mgr`

## Requirements
- R1: During synchronous reset and in the cycle after it, both buffers are empty, buffer 1 is active (`active_sel` = 0), and `active_full`, `active_count`, `nak_o` and `ep_irq` are all 0.
- R2: When `pkt_done` is sampled high and a buffer is free, the packet is stored and `ep_irq` is high for exactly the next cycle. If the active buffer is empty, it takes the packet.
- R3: If a packet arrives while the active buffer is full and the other buffer is empty, the packet goes into the other buffer and raises `ep_irq`. `active_sel` and `active_count` do not change.
- R4: `nak_o` is 1 exactly while both buffers are full. A packet that arrives then is dropped: `ep_irq` stays 0 and neither flag nor count changes.
- R5: A clear command (`sw_clear` = 1) with the active buffer full empties that buffer and toggles `active_sel`. `active_full` and `active_count` then show the other buffer.
- R6: `active_sel` changes only in the cycle after a clear or validate command.
- R7: A clear or validate command issued while the active buffer is empty is ignored. `active_sel` and all outputs stay the same.
- R8: Each buffer stores the 7-bit byte count `pkt_len` (0 to 64) of its packet. `active_count` shows the count of the active buffer while that buffer is full, and 0 otherwise.
- R9: When a packet and a clear command arrive in the same cycle, the clear is applied first. The packet can therefore go into the buffer that was just freed, even when both buffers were full.
- R10: When `HAS_VALIDATE` = 1 (the default), `sw_validate` has the same effect as `sw_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done | input | 1 | A received OUT packet completes this cycle |
| pkt_len | input | 7 | Byte count of the completing packet |
| sw_clear | input | 1 | Clear command for the active buffer |
| sw_validate | input | 1 | Validate command, acts the same as clear |
| active_sel | output | 1 | Active buffer (0 = buffer 1, 1 = buffer 2) |
| active_full | output | 1 | The active buffer holds a packet |
| active_count | output | 7 | Byte count of the active buffer, 0 when it is empty |
| nak_o | output | 1 | Both buffers are full; NAK the next packet |
| ep_irq | output | 1 | One-cycle pulse for each stored packet |

## Verification
A packet completion and a clear command can fall in the same cycle, and the order in which the block handles them decides whether the packet is kept. The bench drives both pulses on the same clock edge in two situations. In the first, both buffers are full, so the packet survives only because the clear comes first. In the second, only the active buffer is full, so the packet has to land in the newly active buffer. In each case the bench compares the active selection, the shown count, the interrupt pulse and the NAK level one cycle later against its own model, and the model applies the clear before the packet.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int MAX_BYTES = 64;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  typedef logic [CNT_W-1:0] bytecnt_t;

  typedef enum logic {
    SLOT_ONE = 1'b0,
    SLOT_TWO = 1'b1
  } slot_e;
endpackage

// File: rtl/pp_slot.sv
// One buffer's bookkeeping: occupancy flag and stored byte count.
module pp_slot #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_i,
  input  logic             free_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full_o <= 1'b0;
      cnt_o  <= '0;
    end else if (fill_i) begin
      // fill wins over free: a freed slot may be refilled in the same cycle
      full_o <= 1'b1;
      cnt_o  <= len_i;
    end else if (free_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_steer.sv
// Combinational decision: applies the command first, then places the packet.
module pp_steer #(
  parameter int NSLOT = 2
) (
  input  logic             act_i,
  input  logic [NSLOT-1:0] full_i,
  input  logic             cmd_i,
  input  logic             pkt_i,
  output logic [NSLOT-1:0] free_o,
  output logic [NSLOT-1:0] fill_o,
  output logic [NSLOT-1:0] full_next_o,
  output logic             act_next_o,
  output logic             accept_o
);
  logic             cmd_eff;
  logic [NSLOT-1:0] full_mid;
  logic             tgt;

  always_comb begin
    cmd_eff  = cmd_i & full_i[act_i];
    free_o   = '0;
    free_o[act_i] = cmd_eff;
    full_mid = full_i & ~free_o;
    act_next_o = cmd_eff ? ~act_i : act_i;

    fill_o   = '0;
    accept_o = 1'b0;
    tgt      = act_next_o;
    if (pkt_i) begin
      if (!full_mid[act_next_o]) begin
        tgt      = act_next_o;
        accept_o = 1'b1;
      end else if (!full_mid[~act_next_o]) begin
        tgt      = ~act_next_o;
        accept_o = 1'b1;
      end
    end
    fill_o[tgt]  = accept_o;
    full_next_o  = full_mid | fill_o;
  end
endmodule

// File: rtl/bulk_pingpong_mgr.sv
module bulk_pingpong_mgr #(
  parameter int MAX_BYTES    = pp_pkg::MAX_BYTES,
  parameter bit HAS_VALIDATE = 1'b1,
  localparam int CNT_W       = $clog2(MAX_BYTES + 1),
  localparam int NSLOT       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_done,
  input  logic [CNT_W-1:0] pkt_len,
  input  logic             sw_clear,
  input  logic             sw_validate,
  output logic             active_sel,
  output logic             active_full,
  output logic [CNT_W-1:0] active_count,
  output logic             nak_o,
  output logic             ep_irq
);
  logic             cmd;
  logic [NSLOT-1:0] full_q;
  logic [CNT_W-1:0] cnt_q [NSLOT];
  logic [NSLOT-1:0] free_v, fill_v, full_nx;
  logic             act_nx, accept;
  logic [CNT_W-1:0] cnt_nx_act;

  generate
    if (HAS_VALIDATE) begin : g_val
      assign cmd = sw_clear | sw_validate;
    end else begin : g_noval
      assign cmd = sw_clear;
    end
  endgenerate

  pp_steer #(.NSLOT(NSLOT)) u_steer (
    .act_i       (active_sel),
    .full_i      (full_q),
    .cmd_i       (cmd),
    .pkt_i       (pkt_done),
    .free_o      (free_v),
    .fill_o      (fill_v),
    .full_next_o (full_nx),
    .act_next_o  (act_nx),
    .accept_o    (accept)
  );

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      pp_slot #(.CNT_W(CNT_W)) u_slot (
        .clk    (clk),
        .rst    (rst),
        .fill_i (fill_v[i]),
        .free_i (free_v[i]),
        .len_i  (pkt_len),
        .full_o (full_q[i]),
        .cnt_o  (cnt_q[i])
      );
    end
  endgenerate

  always_comb begin
    if (fill_v[act_nx])       cnt_nx_act = pkt_len;
    else if (full_nx[act_nx]) cnt_nx_act = cnt_q[act_nx];
    else                      cnt_nx_act = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_sel   <= pp_pkg::SLOT_ONE;
      active_full  <= 1'b0;
      active_count <= '0;
      nak_o        <= 1'b0;
      ep_irq       <= 1'b0;
    end else begin
      active_sel   <= act_nx;
      active_full  <= full_nx[act_nx];
      active_count <= cnt_nx_act;
      nak_o        <= &full_nx;
      ep_irq       <= accept;
    end
  end
endmodule

// File: rtl/pp_checker.sv
module pp_checker (
  input logic clk,
  input logic rst,
  input logic pkt_done,
  input logic sw_clear,
  input logic sw_validate,
  input logic active_sel,
  input logic active_full,
  input logic nak_o,
  input logic ep_irq
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (active_sel == 1'b0 && !active_full && !nak_o && !ep_irq));

  assert_irq_cause_R2: assert property (@(posedge clk) disable iff (rst)
    ep_irq |-> $past(pkt_done));

  assert_nak_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (nak_o && pkt_done && !sw_clear && !sw_validate) |=> !ep_irq);

  assert_clear_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_clear && active_full) |=> (active_sel != $past(active_sel)));

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(sw_clear || sw_validate) |=> $stable(active_sel));

  assert_empty_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ((sw_clear || sw_validate) && !active_full) |=> $stable(active_sel));

  assert_clear_then_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (sw_clear && active_full && pkt_done) |=> ep_irq);
endmodule

bind bulk_pingpong_mgr pp_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .pkt_done    (pkt_done),
  .sw_clear    (sw_clear),
  .sw_validate (sw_validate),
  .active_sel  (active_sel),
  .active_full (active_full),
  .nak_o       (nak_o),
  .ep_irq      (ep_irq)
);

// File: tb/bulk_pingpong_mgr_bench.sv
`timescale 1ns/1ps
module bulk_pingpong_mgr_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pkt_done = 1'b0;
  logic [6:0] pkt_len = '0;
  logic       sw_clear = 1'b0;
  logic       sw_validate = 1'b0;
  logic       active_sel, active_full, nak_o, ep_irq;
  logic [6:0] active_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic       sel;
    logic       full;
    logic [6:0] cnt;
    logic       nak;
    logic       irq;
  } exp_t;

  exp_t exp_q[$];

  logic       m_full [2];
  logic [6:0] m_cnt  [2];
  logic       m_act;

  always #4 clk = ~clk;

  bulk_pingpong_mgr u_bulk_pingpong_mgr (
    .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .sw_clear(sw_clear), .sw_validate(sw_validate),
    .active_sel(active_sel), .active_full(active_full),
    .active_count(active_count), .nak_o(nak_o), .ep_irq(ep_irq)
  );

  // driver: drive one cycle, update the model, push the expectation
  task automatic step(input string tag, input logic p, input logic [6:0] len,
                      input logic c, input logic v);
    exp_t e;
    logic irq;
    logic tgt;
    @(negedge clk);
    pkt_done = p; pkt_len = len; sw_clear = c; sw_validate = v;
    @(posedge clk);
    #1;
    if ((c || v) && m_full[m_act]) begin
      m_full[m_act] = 1'b0;
      m_act = ~m_act;
    end
    irq = 1'b0;
    if (p) begin
      if (!m_full[m_act]) begin tgt = m_act; irq = 1'b1; end
      else if (!m_full[~m_act]) begin tgt = ~m_act; irq = 1'b1; end
      else tgt = m_act;
      if (irq) begin m_full[tgt] = 1'b1; m_cnt[tgt] = len; end
    end
    e.tag  = tag;
    e.sel  = m_act;
    e.full = m_full[m_act];
    e.cnt  = m_full[m_act] ? m_cnt[m_act] : 7'd0;
    e.nak  = m_full[0] & m_full[1];
    e.irq  = irq;
    exp_q.push_back(e);
    pkt_done = 1'b0; sw_clear = 1'b0; sw_validate = 1'b0;
  endtask

  // monitor: compare outputs away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (active_sel !== e.sel || active_full !== e.full || active_count !== e.cnt ||
          nak_o !== e.nak || ep_irq !== e.irq) begin
        errors++;
        $display("FAIL %s: got sel=%0b full=%0b cnt=%0d nak=%0b irq=%0b, expected sel=%0b full=%0b cnt=%0d nak=%0b irq=%0b",
                 e.tag, active_sel, active_full, active_count, nak_o, ep_irq,
                 e.sel, e.full, e.cnt, e.nak, e.irq);
      end
    end
  end

  initial begin
    m_full[0] = 1'b0; m_full[1] = 1'b0;
    m_cnt[0] = '0; m_cnt[1] = '0;
    m_act = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (active_sel !== 1'b0 || active_full !== 1'b0 || active_count !== 7'd0 ||
        nak_o !== 1'b0 || ep_irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: got sel=%0b full=%0b cnt=%0d nak=%0b irq=%0b, expected all 0",
               active_sel, active_full, active_count, nak_o, ep_irq);
    end
    rst = 1'b0;
    step("R1 idle after reset", 0, 0, 0, 0);
    step("R2 first packet into active", 1, 7'd10, 0, 0);
    step("R2 irq single pulse", 0, 0, 0, 0);
    step("R3 second packet to other buffer", 1, 7'd64, 0, 0);
    step("R4 both full packet dropped", 1, 7'd5, 0, 0);
    step("R6 no command keeps active", 0, 0, 0, 0);
    step("R5 clear frees and toggles", 0, 0, 1, 0);
    step("R8 zero-length packet stored", 1, 7'd0, 0, 0);
    step("R9 clear with both full then packet", 1, 7'd33, 1, 0);
    step("R10 validate acts as clear", 0, 0, 0, 1);
    step("R5 clear to both empty", 0, 0, 1, 0);
    step("R7 clear on empty ignored", 0, 0, 1, 0);
    step("R7 validate on empty ignored", 0, 0, 0, 1);
    step("R2 packet into empty active", 1, 7'd7, 0, 0);
    step("R9 clear with one full then packet", 1, 7'd12, 1, 0);
    step("R6 idle keeps active", 0, 0, 0, 0);
    step("R8 count 64 in other buffer", 1, 7'd64, 0, 0);
    step("R4 nak level with both full", 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule